// File: doc/BRIEF.md
# Timing Link Frame Multiplexer

This block builds the word stream that a timing generator sends to its receivers, one 16-bit word per link clock. The upper byte of every word is an event code taken from an event queue, or a null code when the queue is empty. The lower byte is a shared data lane. Protection-system status and bytes of a distributed data buffer take turns on it, and a lane flag sent with each word tells the receiver which of the two the lane carries.

The distributed buffer is held in an internal RAM with a byte write port. A transfer is started with a strobe and the index of the last byte. Buffer bytes then go out in address order, one on every second word, and a done pulse marks the word that carries the final byte. When no transfer is running, every data slot carries protection data. Protection status is a multi-byte word. The block keeps repeating the current status byte while the status is unchanged. When the status changes, the block moves on to the next byte position.

Top module: `tlm_frame_mux`

## Requirements
- R1: While reset is held, `link_word` is 0x0000 and `link_lane_buf` and `buf_done` are 0. The protection snapshot and byte index clear to zero.
- R2: If `evq_valid` is high at a clock edge, then `evq_pop` is high in that cycle and `link_word[15:8]` after the edge equals `evq_code`. If `evq_valid` is low, `link_word[15:8]` after the edge is the null code 0x00.
- R3: Words are numbered 1, 2, 3, ... from the first clock edge after reset. Odd-numbered words always carry protection data. Buffer bytes (`link_lane_buf`=1) appear only on even-numbered words, so two buffer words are never adjacent.
- R4: On each word whose data lane carries protection data, the block compares `prot_status` at that edge with the stored snapshot. If they are equal, the byte at the current index of the snapshot is repeated. If they differ, the snapshot takes the new status, the index advances by one (wrapping after PROT_BYTES-1), and the lane carries byte [8*index+7:8*index] of the new status.
- R5: A transfer sends buffer bytes from address 0 up to `buf_last` in address order, with `link_lane_buf`=1 and the byte in `link_word[7:0]`. Exactly `buf_last`+1 bytes are sent, including the single-byte case (`buf_last`=0) and the full-RAM case (`buf_last`=DEPTH-1).
- R6: A `buf_start` that arrives while a transfer is running is ignored. The running transfer keeps its length and order.
- R7: `buf_done` is a single-cycle pulse that rises with the word carrying the last buffer byte, and it is low on every other word.
- R8: When no transfer is running, no word has `link_lane_buf`=1. Every data slot then carries protection data.
- R9: A byte written through `buf_wr_en`/`buf_wr_addr`/`buf_wr_data` while idle is the byte sent for that address by later transfers, and overwriting a byte replaces it.
- R10: If `buf_start` is accepted at the edge of word s, byte 0 appears on word s+2 when s is even and on word s+3 when s is odd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evq_valid | input | 1 | Event queue has a code at its head |
| evq_code | input | 8 | Event code at the queue head |
| evq_pop | output | 1 | Head code is consumed this cycle |
| prot_status | input | PROT_BYTES*8 | Live protection status word |
| buf_wr_en | input | 1 | Buffer RAM write enable |
| buf_wr_addr | input | AW | Buffer RAM write address |
| buf_wr_data | input | 8 | Buffer RAM write byte |
| buf_start | input | 1 | Start a buffer transfer (taken only while idle) |
| buf_last | input | AW | Index of the last byte to send |
| buf_done | output | 1 | Pulse with the word carrying the last buffer byte |
| link_word | output | 16 | Event code in [15:8], data lane in [7:0] |
| link_lane_buf | output | 1 | 1: lane carries a buffer byte; 0: protection byte |

## Verification
The in-RTL assertions check on every cycle that queued codes and null codes reach the event byte and that a done pulse only comes with a buffer word. They also check that buffer words are never adjacent, that the protection index holds while the status is unchanged, and that a start during a transfer leaves its length untouched. Only the bench's scenarios can show the complete byte order of a transfer against the written RAM contents, the start-to-first-byte latency at both slot parities, and the full-depth and single-byte lengths. They also show the exact protection byte sequence as the status changes, and that an ignored start really leaves the byte count unchanged.

// File: rtl/tlm_pkg.sv
package tlm_pkg;

    localparam logic [7:0] NULL_CODE = 8'h00;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // Output stage of the link word
    typedef struct packed {
        logic        phase;   // 0: next word is a protection (fetch) slot
        logic [15:0] word;
        logic        lane;
        logic        done;
    } link_regs_t;

endpackage

// File: rtl/tlm_buf_ram.sv
module tlm_buf_ram #(
    parameter int DEPTH = 2048,
    parameter int AW    = 11
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
        if (rd_en) begin
            rd_data <= mem[rd_addr];
        end
    end

endmodule

// File: rtl/tlm_prot_sel.sv
module tlm_prot_sel #(
    parameter int PROT_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    take,
    input  logic [PROT_BYTES*8-1:0] status,
    output logic [7:0]              byte_o
);

    localparam int SW = PROT_BYTES * 8;
    localparam int IW = (PROT_BYTES > 1) ? $clog2(PROT_BYTES) : 1;
    localparam logic [IW-1:0] IDX_TOP = IW'(PROT_BYTES - 1);

    typedef struct packed {
        logic [SW-1:0] snap;
        logic [IW-1:0] idx;
    } prot_t;

    prot_t q, n;

    always_comb begin
        n = q;
        if (take && (status != q.snap)) begin
            n.snap = status;
            n.idx  = (q.idx == IDX_TOP) ? '0 : q.idx + 1'b1;
        end
        byte_o = n.snap[{n.idx, 3'b000} +: 8];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    // R4: unchanged status keeps the same byte position and snapshot
    a_r4_hold_index: assert property (@(posedge clk) disable iff (!rst_n)
        (take && status == q.snap) |=> ($stable(q.idx) && $stable(q.snap)));

    // R4: a change is captured into the snapshot
    a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (take && status != q.snap) |=> (q.snap == $past(status)));

endmodule

// File: rtl/tlm_buf_seq.sv
module tlm_buf_seq
    import tlm_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_slot,
    input  logic          start,
    input  logic [AW-1:0] last_in,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic          use_buf,
    output logic          last_byte
);

    typedef struct packed {
        seq_state_e    state;
        logic [AW-1:0] ptr;
        logic [AW-1:0] last;
        logic          issued_all;
        logic          pend;
        logic          pend_last;
    } seq_t;

    seq_t q, n;

    always_comb begin
        n           = q;
        n.pend      = 1'b0;
        n.pend_last = 1'b0;
        rd_en       = 1'b0;
        unique case (q.state)
            SEQ_IDLE: begin
                if (start) begin
                    n.state      = SEQ_RUN;
                    n.ptr        = '0;
                    n.last       = last_in;
                    n.issued_all = 1'b0;
                end
            end
            SEQ_RUN: begin
                if (fetch_slot && !q.issued_all) begin
                    rd_en       = 1'b1;
                    n.pend      = 1'b1;
                    n.pend_last = (q.ptr == q.last);
                    if (q.ptr == q.last) begin
                        n.issued_all = 1'b1;
                    end else begin
                        n.ptr = q.ptr + 1'b1;
                    end
                end
                if (q.pend && q.pend_last) begin
                    n.state = SEQ_IDLE;
                end
            end
            default: n.state = SEQ_IDLE;
        endcase
    end

    assign rd_addr   = q.ptr;
    assign use_buf   = q.pend;
    assign last_byte = q.pend && q.pend_last;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    // R6: a start while running leaves the transfer length untouched
    a_r6_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == SEQ_RUN && start) |=> $stable(q.last));

    // R5: the read pointer never passes the last index
    a_r5_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == SEQ_RUN) |-> (q.ptr <= q.last));

    // R3: fetches only happen in protection slots, so delivered bytes alternate
    a_r3_fetch_slot: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !rd_en);

endmodule

// File: rtl/tlm_frame_mux.sv
module tlm_frame_mux
    import tlm_pkg::*;
#(
    parameter int DEPTH      = 2048,
    parameter int PROT_BYTES = 4,
    parameter int AW         = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    evq_valid,
    input  logic [7:0]              evq_code,
    output logic                    evq_pop,
    input  logic [PROT_BYTES*8-1:0] prot_status,
    input  logic                    buf_wr_en,
    input  logic [AW-1:0]           buf_wr_addr,
    input  logic [7:0]              buf_wr_data,
    input  logic                    buf_start,
    input  logic [AW-1:0]           buf_last,
    output logic                    buf_done,
    output logic [15:0]             link_word,
    output logic                    link_lane_buf
);

    link_regs_t q, n;

    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data;
    logic          use_buf;
    logic          last_byte;
    logic [7:0]    prot_byte;

    tlm_buf_ram #(
        .DEPTH (DEPTH),
        .AW    (AW)
    ) u_ram (
        .clk     (clk),
        .wr_en   (buf_wr_en),
        .wr_addr (buf_wr_addr),
        .wr_data (buf_wr_data),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    tlm_buf_seq #(
        .AW (AW)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_slot (~q.phase),
        .start      (buf_start),
        .last_in    (buf_last),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .use_buf    (use_buf),
        .last_byte  (last_byte)
    );

    tlm_prot_sel #(
        .PROT_BYTES (PROT_BYTES)
    ) u_prot (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (~use_buf),
        .status (prot_status),
        .byte_o (prot_byte)
    );

    always_comb begin
        n       = q;
        n.phase = ~q.phase;
        n.word  = {(evq_valid ? evq_code : NULL_CODE),
                   (use_buf ? rd_data : prot_byte)};
        n.lane  = use_buf;
        n.done  = last_byte;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    assign evq_pop       = evq_valid;
    assign link_word     = q.word;
    assign link_lane_buf = q.lane;
    assign buf_done      = q.done;

    // R2: a queued code reaches the event byte of the next word
    a_r2_code_pass: assert property (@(posedge clk) disable iff (!rst_n)
        evq_valid |=> (link_word[15:8] == $past(evq_code)));

    // R2: an empty queue yields the null code
    a_r2_null_code: assert property (@(posedge clk) disable iff (!rst_n)
        !evq_valid |=> (link_word[15:8] == NULL_CODE));

    // R7: done only accompanies a buffer byte
    a_r7_done_with_byte: assert property (@(posedge clk) disable iff (!rst_n)
        buf_done |-> link_lane_buf);

    // R3: buffer words are never back to back
    a_r3_no_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
        link_lane_buf |=> !link_lane_buf);

endmodule

// File: tb/tlm_frame_mux_tb.sv
`timescale 1ns/1ps
module tlm_frame_mux_tb;

    localparam int DEPTH = 2048;
    localparam int PB    = 4;
    localparam int AW    = 11;
    localparam int SW    = PB * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          evq_valid = 1'b0;
    logic [7:0]    evq_code = '0;
    logic          evq_pop;
    logic [SW-1:0] prot_status = '0;
    logic          buf_wr_en = 1'b0;
    logic [AW-1:0] buf_wr_addr = '0;
    logic [7:0]    buf_wr_data = '0;
    logic          buf_start = 1'b0;
    logic [AW-1:0] buf_last = '0;
    logic          buf_done;
    logic [15:0]   link_word;
    logic          link_lane_buf;

    always #2 clk = ~clk;

    tlm_frame_mux #(.DEPTH(DEPTH), .PROT_BYTES(PB)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .evq_valid(evq_valid), .evq_code(evq_code), .evq_pop(evq_pop),
        .prot_status(prot_status),
        .buf_wr_en(buf_wr_en), .buf_wr_addr(buf_wr_addr), .buf_wr_data(buf_wr_data),
        .buf_start(buf_start), .buf_last(buf_last), .buf_done(buf_done),
        .link_word(link_word), .link_lane_buf(link_lane_buf)
    );

    int total = 0;
    int bad   = 0;
    int wcount = 0;
    bit bg_on = 0;
    bit finished = 0;

    logic [7:0]    m_mem [DEPTH];
    logic [SW-1:0] m_snap = '0;
    int            m_idx = 0;
    bit            m_busy = 0;
    int            m_rd = 0;
    int            m_last = 0;
    int            m_first = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h (word %0d)", req, act, exp, wcount);
        end
    endtask

    task automatic tick();
        logic [7:0]    e_evt;
        logic [SW-1:0] st;
        logic [7:0]    e_dat;
        if (bg_on) begin
            evq_valid   = (wcount % 3) != 0;
            evq_code    = 8'(wcount * 5 + 1);
            prot_status = 32'h5A3C_0F96 ^ (32'(wcount / 7) * 32'h0103_0507);
        end
        e_evt = evq_valid ? evq_code : 8'h00;
        st    = prot_status;
        chk(evq_pop == evq_valid, "R2 pop", int'(evq_pop), int'(evq_valid));
        @(posedge clk);
        @(negedge clk);
        wcount++;
        chk(link_word[15:8] == e_evt, "R2 event byte", int'(link_word[15:8]), int'(e_evt));
        if (link_lane_buf) begin
            chk(m_busy, "R8 buffer byte while idle", 1, 0);
            chk((wcount % 2) == 0, "R3 buffer on odd word", wcount % 2, 0);
            if (m_rd == 0)
                chk(wcount == m_first, "R10 first byte latency", wcount, m_first);
            e_dat = (m_rd < DEPTH) ? m_mem[m_rd] : 8'h00;
            chk(link_word[7:0] == e_dat, "R5 byte order", int'(link_word[7:0]), int'(e_dat));
            chk(buf_done == (m_rd == m_last), "R7 done placement", int'(buf_done), int'(m_rd == m_last));
            if (m_rd == m_last) m_busy = 0;
            m_rd++;
        end else begin
            chk(!buf_done, "R7 done without byte", int'(buf_done), 0);
            if (st != m_snap) begin
                m_snap = st;
                m_idx  = (m_idx + 1) % PB;
            end
            e_dat = m_snap[m_idx*8 +: 8];
            chk(link_word[7:0] == e_dat, "R4 protection byte", int'(link_word[7:0]), int'(e_dat));
        end
    endtask

    task automatic start_xfer(input int last);
        buf_start = 1'b1;
        buf_last  = AW'(last);
        tick();
        buf_start = 1'b0;
        m_busy  = 1;
        m_rd    = 0;
        m_last  = last;
        m_first = (wcount % 2 == 1) ? wcount + 3 : wcount + 2;
    endtask

    task automatic wait_done(input int inject_at, input string req);
        int k = 0;
        while (m_busy && k < 2 * DEPTH + 16) begin
            if (k == inject_at) begin
                buf_start = 1'b1;
                buf_last  = AW'(5);
            end
            tick();
            buf_start = 1'b0;
            k++;
        end
        chk(!m_busy, "R5 transfer completes", int'(m_busy), 0);
        chk(m_rd == m_last + 1, req, m_rd, m_last + 1);
    endtask

    task automatic write_byte(input int a, input logic [7:0] d);
        buf_wr_en   = 1'b1;
        buf_wr_addr = AW'(a);
        buf_wr_data = d;
        m_mem[a]    = d;
        tick();
        buf_wr_en   = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", wcount, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        prot_status = 32'h1122_3344;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(link_word == 16'h0000, "R1 reset word", int'(link_word), 0);
        chk(!link_lane_buf, "R1 reset lane", int'(link_lane_buf), 0);
        chk(!buf_done, "R1 reset done", int'(buf_done), 0);
        rst_n = 1'b1;

        // R2: every event code, then empty queue gives null code
        for (int c = 0; c < 256; c++) begin
            evq_valid = 1'b1;
            evq_code  = 8'(c);
            tick();
        end
        evq_valid = 1'b0;
        repeat (4) tick();

        // R4: status held for three words, then changed
        for (int i = 0; i < 48; i++) begin
            prot_status = 32'h0A0B_0C0D ^ (32'(i / 3) * 32'h0101_0101);
            tick();
        end

        // R9: fill the buffer RAM
        for (int a = 0; a < DEPTH; a++) begin
            write_byte(a, 8'((a * 7 + 3) ^ (a >> 3)));
        end

        bg_on = 1;
        // R5 single-byte transfer
        start_xfer(0);
        wait_done(-1, "R5 single byte count");
        // R8: idle words carry no buffer data
        repeat (7) tick();
        // R10: typical length at both parities
        start_xfer(29);
        wait_done(-1, "R5 length 30 count");
        tick();
        start_xfer(29);
        wait_done(-1, "R5 length 30 count");
        repeat (3) tick();
        // R6: full-depth transfer with a start injected midway
        start_xfer(DEPTH - 1);
        wait_done(100, "R6 ignored start keeps length");
        repeat (5) tick();

        // R9: overwrite a few bytes and resend
        bg_on = 0;
        evq_valid = 1'b0;
        for (int a = 0; a < 4; a++) write_byte(a, 8'(8'hC0 + a));
        bg_on = 1;
        start_xfer(3);
        wait_done(-1, "R9 overwritten bytes count");
        repeat (4) tick();

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule